// File: doc/BRIEF.md
# Two-Stage Segmented Unsigned Magnitude Comparator

This block orders two 32-bit unsigned operands and reports one of three relations: first operand greater, equal, or smaller. The work is spread over two register stages so that no single carry chain spans the full operand width within one cycle. The comparison is written out as explicit logic per segment, with no library comparator.

A parameter picks how the operands are cut. In the halves variant, the upper 16 bits are ordered in the first stage and the lower 16 bits in the second; the lower result counts only when the upper halves match. In the bytes variant, all four byte pairs are ordered in parallel in the first stage, and the second stage merges them from the most significant byte down. Either way a new pair may enter on every cycle, and its result appears two cycles later.

Top module: `segcmp_top`

## Requirements
- R1: `res_vld` is high exactly two clock cycles after `in_vld` was high, in both split variants, and a new operand pair is accepted on every cycle.
- R2: While `res_vld` is high, exactly one of `res_gt`, `res_eq`, `res_lt` is high.
- R3: `res_gt` is high when `opa` > `opb` as unsigned 32-bit values, `res_lt` when `opa` < `opb`, and `res_eq` when they are equal.
- R4: In the halves variant (`SPLIT_BYTES`=0), a difference in bits 31..16 decides the result regardless of bits 15..0; when bits 31..16 match, bits 15..0 decide.
- R5: In the bytes variant (`SPLIT_BYTES`=1), the most significant unequal byte (byte 3 = bits 31..24 down to byte 0 = bits 7..0) decides the result.
- R6: While `rst_n` is low, and on the first cycles after its release with no input, `res_vld`, `res_gt`, `res_eq` and `res_lt` are all zero.
- R7: A cycle with `in_vld` low produces a cycle with `res_vld` low and all three flags zero two cycles later, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Operand pair valid |
| opa | input | 32 | First operand, unsigned |
| opb | input | 32 | Second operand, unsigned |
| res_vld | output | 1 | Result valid, two cycles after `in_vld` |
| res_gt | output | 1 | `opa` greater than `opb` |
| res_eq | output | 1 | Operands equal |
| res_lt | output | 1 | `opa` less than `opb` |

## Verification
The bench targets the segment boundaries: operands that differ only in bit 0 or only in bit 31, pairs whose upper halves or upper bytes match while lower parts differ in both directions, and pairs where a high segment and a low segment disagree on the direction. A merge that let a lower segment override a higher one would report the wrong direction on those conflict pairs, and one that used a stale upper-half flag would report equality when only bit 0 differs. Back-to-back pairs with gaps between them show a misaligned stage as results landing a cycle early or late, or as flags that stay high on an idle cycle.

// File: rtl/segcmp_pkg.sv
package segcmp_pkg;
  localparam int unsigned OP_W = 32;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  // Hand-written ordering of two equal-width slices: scan from MSB down.
  function automatic logic [1:0] seg_order(input logic [15:0] a, input logic [15:0] b, input int unsigned w);
    logic g, e;
    g = 1'b0;
    e = 1'b1;
    for (int i = 15; i >= 0; i--) begin
      if (i < int'(w)) begin
        g = g | (e & a[i] & ~b[i]);
        e = e & ~(a[i] ^ b[i]);
      end
    end
    return {g, e};
  endfunction
endpackage

// File: rtl/segcmp_slice.sv
module segcmp_slice #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         eq
);
  logic [15:0] a_ext, b_ext;
  logic [1:0]  ge;

  always_comb begin
    a_ext = '0;
    b_ext = '0;
    a_ext[W-1:0] = a;
    b_ext[W-1:0] = b;
    ge = segcmp_pkg::seg_order(a_ext, b_ext, W);
    gt = ge[1];
    eq = ge[0];
  end
endmodule

// File: rtl/segcmp_halves.sv
module segcmp_halves
  import segcmp_pkg::*;
#(
  parameter int unsigned W = OP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         v_mid,
  output rel_t         rel_nxt
);
  localparam int unsigned HW = W / 2;

  logic          hi_gt, hi_eq;
  logic          lo_gt, lo_eq;
  logic          hi_gt_q, hi_eq_q, v_q;
  logic [HW-1:0] a_lo_q, b_lo_q;
  logic          hi_gt_d, hi_eq_d;

  segcmp_slice #(.W(HW)) u_hi (.a(a[W-1:HW]), .b(b[W-1:HW]), .gt(hi_gt), .eq(hi_eq));

  always_comb begin
    hi_gt_d = v_in & hi_gt;
    hi_eq_d = v_in & hi_eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      hi_gt_q <= 1'b0;
      hi_eq_q <= 1'b0;
    end else begin
      v_q     <= v_in;
      hi_gt_q <= hi_gt_d;
      hi_eq_q <= hi_eq_d;
    end
  end

  // Data registers need no reset; enabled only on valid input.
  always_ff @(posedge clk) begin
    if (v_in) begin
      a_lo_q <= a[HW-1:0];
      b_lo_q <= b[HW-1:0];
    end
  end

  segcmp_slice #(.W(HW)) u_lo (.a(a_lo_q), .b(b_lo_q), .gt(lo_gt), .eq(lo_eq));

  always_comb begin
    v_mid      = v_q;
    rel_nxt.gt = v_q & (hi_gt_q | (hi_eq_q & lo_gt));
    rel_nxt.eq = v_q & hi_eq_q & lo_eq;
    rel_nxt.lt = v_q & ~hi_gt_q & ~(hi_eq_q & (lo_gt | lo_eq));
  end
endmodule

// File: rtl/segcmp_bytes.sv
module segcmp_bytes
  import segcmp_pkg::*;
#(
  parameter int unsigned W   = OP_W,
  parameter int unsigned SEG = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         v_in,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         v_mid,
  output rel_t         rel_nxt
);
  localparam int unsigned NSEG = W / SEG;

  logic [NSEG-1:0] gt_c, eq_c, gt_q, eq_q;
  logic            v_q;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    segcmp_slice #(.W(SEG)) u_s (
      .a (a[s*SEG +: SEG]),
      .b (b[s*SEG +: SEG]),
      .gt(gt_c[s]),
      .eq(eq_c[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      gt_q <= '0;
      eq_q <= '0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        gt_q <= gt_c;
        eq_q <= eq_c;
      end
    end
  end

  // Priority merge: highest unequal segment decides.
  always_comb begin
    logic g, e;
    g = 1'b0;
    e = 1'b1;
    for (int s = NSEG - 1; s >= 0; s--) begin
      g = g | (e & gt_q[s]);
      e = e & eq_q[s];
    end
    v_mid      = v_q;
    rel_nxt.gt = v_q & g;
    rel_nxt.eq = v_q & e;
    rel_nxt.lt = v_q & ~g & ~e;
  end
endmodule

// File: rtl/segcmp_top.sv
module segcmp_top
  import segcmp_pkg::*;
#(
  parameter bit SPLIT_BYTES = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [OP_W-1:0] opa,
  input  logic [OP_W-1:0] opb,
  output logic            res_vld,
  output logic            res_gt,
  output logic            res_eq,
  output logic            res_lt
);
  logic rst_s1_n, rst_s2_n;
  logic v_mid;
  rel_t rel_nxt, rel_q;
  logic vld_q;

  // Async assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_n <= 1'b0;
      rst_s2_n <= 1'b0;
    end else begin
      rst_s1_n <= 1'b1;
      rst_s2_n <= rst_s1_n;
    end
  end

  if (SPLIT_BYTES) begin : g_bytes
    segcmp_bytes #(.W(OP_W), .SEG(8)) u_cmp (
      .clk(clk), .rst_n(rst_s2_n), .v_in(in_vld), .a(opa), .b(opb),
      .v_mid(v_mid), .rel_nxt(rel_nxt)
    );
  end else begin : g_halves
    segcmp_halves #(.W(OP_W)) u_cmp (
      .clk(clk), .rst_n(rst_s2_n), .v_in(in_vld), .a(opa), .b(opb),
      .v_mid(v_mid), .rel_nxt(rel_nxt)
    );
  end

  always_ff @(posedge clk or negedge rst_s2_n) begin
    if (!rst_s2_n) begin
      vld_q <= 1'b0;
      rel_q <= '0;
    end else begin
      vld_q <= v_mid;
      rel_q <= rel_nxt;
    end
  end

  assign res_vld = vld_q;
  assign res_gt  = rel_q.gt;
  assign res_eq  = rel_q.eq;
  assign res_lt  = rel_q.lt;
endmodule

// File: rtl/segcmp_chk.sv
module segcmp_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_vld,
  input logic [31:0] opa,
  input logic [31:0] opb,
  input logic        res_vld,
  input logic        res_gt,
  input logic        res_eq,
  input logic        res_lt
);
  logic [1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (seen != 2'd3) seen <= seen + 2'd1;
  end

  // R1
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen == 2'd3) |-> (res_vld == $past(in_vld, 2)));

  // R2
  onehot_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> ($countones({res_gt, res_eq, res_lt}) == 1));

  // R3
  order_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((seen == 2'd3) && res_vld) |->
      (res_gt == ($past(opa, 2) > $past(opb, 2))) && (res_eq == ($past(opa, 2) == $past(opb, 2))));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(res_gt | res_eq | res_lt));
endmodule

bind segcmp_top segcmp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .opa(opa), .opb(opb),
  .res_vld(res_vld), .res_gt(res_gt), .res_eq(res_eq), .res_lt(res_lt)
);

// File: tb/segcmp_top_tb_top.sv
module segcmp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld [2];
  logic [31:0] opa [2];
  logic [31:0] opb [2];
  logic        res_vld [2];
  logic        res_gt [2];
  logic        res_eq [2];
  logic        res_lt [2];

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  segcmp_top #(.SPLIT_BYTES(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld[0]), .opa(opa[0]), .opb(opb[0]),
    .res_vld(res_vld[0]), .res_gt(res_gt[0]), .res_eq(res_eq[0]), .res_lt(res_lt[0])
  );

  segcmp_top #(.SPLIT_BYTES(1'b1)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld[1]), .opa(opa[1]), .opb(opb[1]),
    .res_vld(res_vld[1]), .res_gt(res_gt[1]), .res_eq(res_eq[1]), .res_lt(res_lt[1])
  );

  task automatic chk(input int m, input string req, input logic [3:0] got, input logic [3:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s mode%0d: {vld,gt,eq,lt} got %b expected %b", req, m, got, exp);
    end
  endtask

  function automatic logic [3:0] model(input logic v, input logic [31:0] a, input logic [31:0] b);
    if (!v) return 4'b0000;
    if (a > b) return 4'b1100;
    if (a == b) return 4'b1010;
    return 4'b1001;
  endfunction

  // Drive a burst on both instances, one pair per cycle, and check each result two cycles later.
  task automatic run_burst(input string req, input logic v [], input logic [31:0] a [], input logic [31:0] b []);
    int n = a.size();
    for (int i = 0; i < n + 2; i++) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) begin
        in_vld[m] = (i < n) ? v[i] : 1'b0;
        opa[m]    = (i < n) ? a[i] : 32'hDEAD_BEEF;
        opb[m]    = (i < n) ? b[i] : 32'h1234_5678;
      end
      if (i >= 2) begin
        #1;
        for (int m = 0; m < 2; m++)
          chk(m, req, {res_vld[m], res_gt[m], res_eq[m], res_lt[m]}, model(v[i-2], a[i-2], b[i-2]));
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int m = 0; m < 2; m++) begin in_vld[m] = 1'b1; opa[m] = 32'h5; opb[m] = 32'h3; end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) chk(m, "R6", {res_vld[m], res_gt[m], res_eq[m], res_lt[m]}, 4'b0000);
    for (int m = 0; m < 2; m++) in_vld[m] = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      for (int m = 0; m < 2; m++) chk(m, "R6", {res_vld[m], res_gt[m], res_eq[m], res_lt[m]}, 4'b0000);
    end
  endtask

  task automatic t_basic();   // R3 R1: equal, bit 0, bit 31, back to back
    logic v [] = '{1, 1, 1, 1, 1, 1};
    logic [31:0] a [] = '{32'h0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0, 32'h8000_0000, 32'h0};
    logic [31:0] b [] = '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'h1, 32'h0, 32'h8000_0000};
    run_burst("R3", v, a, b);
  endtask

  task automatic t_halves();  // R4 upper equal, lower both ways; upper disagrees with lower
    logic v [] = '{1, 1, 1, 1, 1};
    logic [31:0] a [] = '{32'hABCD_0010, 32'hABCD_000F, 32'h0002_0000, 32'h0001_FFFF, 32'h7FFF_FFFF};
    logic [31:0] b [] = '{32'hABCD_000F, 32'hABCD_0010, 32'h0001_FFFF, 32'h0002_0000, 32'h8000_0000};
    run_burst("R4", v, a, b);
  endtask

  task automatic t_bytes();   // R5 highest unequal byte wins over lower bytes
    logic v [] = '{1, 1, 1, 1, 1, 1};
    logic [31:0] a [] = '{32'h1102_FFFF, 32'h1101_0000, 32'h1111_12FF, 32'h1111_1100, 32'h1111_1181, 32'h1111_1180};
    logic [31:0] b [] = '{32'h1103_0000, 32'h1100_FFFF, 32'h1111_1300, 32'h1111_10FF, 32'h1111_1180, 32'h1111_1181};
    run_burst("R5", v, a, b);
  endtask

  task automatic t_gaps();    // R7 R1 R2: idle cycles between valid pairs
    logic v [] = '{1, 0, 1, 0, 0, 1, 1};
    logic [31:0] a [] = '{32'h5, 32'h9, 32'h3, 32'hFFFF_FFFF, 32'h0, 32'h7, 32'h7};
    logic [31:0] b [] = '{32'h5, 32'h1, 32'h4, 32'h0, 32'h0, 32'h6, 32'h8};
    run_burst("R7", v, a, b);
  endtask

  task automatic t_walk();    // R2 R3: single-bit differences at every position, both directions
    logic v [64];
    logic [31:0] a [64];
    logic [31:0] b [64];
    for (int i = 0; i < 32; i++) begin
      v[2*i] = 1; a[2*i] = 32'h5A5A_5A5A | (32'h1 << i); b[2*i] = 32'h5A5A_5A5A & ~(32'h1 << i);
      v[2*i+1] = 1; a[2*i+1] = b[2*i]; b[2*i+1] = a[2*i];
    end
    run_burst("R2", v, a, b);
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin in_vld[m] = 1'b0; opa[m] = '0; opb[m] = '0; end
    t_reset();
    t_basic();
    t_halves();
    t_bytes();
    t_gaps();
    t_walk();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule